// File: doc/BRIEF.md
# Register Rename Unit with Branch and Exception Recovery

This block translates the architectural register numbers of one decoded instruction per cycle into physical register tags. A map table gives the current physical home of every architectural register, and a free pool hands out a fresh physical register to every instruction that writes one. Later writers of the same architectural register therefore never share storage with earlier ones, and only true read-after-write ordering remains.

Every renamed instruction is written into an in-order rename log, one slot per instruction. The slot keeps the new physical destination, the mapping that destination replaced, and, for branches, the checkpoint slot in use. A branch also stores a full copy of the map table in a checkpoint slot. A mispredicted branch is recovered in one cycle by reloading that copy. An exception is recovered by walking the log backwards from the youngest entry, one entry per cycle, and writing each recorded previous mapping back into the table. Commit retires the oldest log entry and returns the register it displaced to the free pool.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset every architectural register i maps to physical register i. Physical registers ARCH_REGS and above are free. `ren_ready` is high.
- R2: Source tags are read from the table as it stood before the same instruction's destination update. `ren_pold` returns the destination's mapping before the rename.
- R3: Every renamed destination receives the lowest-numbered free physical register. `ren_ready` is low when a destination is needed and no register is free.
- R4: Architectural register 0 always reads physical register 0. A rename with destination 0 allocates nothing and reports 0 on both `ren_pdst` and `ren_pold`.
- R5: A commit pulse retires the oldest log entry and frees its previous mapping, which can be allocated from the next cycle. A commit pulse is ignored when the log is empty, during a recovery request, or during a walk.
- R6: A branch rename takes the lowest-numbered free checkpoint slot and reports it on `ren_ckpt`. `ren_ready` is low for a branch when no slot is free. A slot is released when its branch commits or is recovered.
- R7: A branch recovery restores the table as it stood just after that branch was renamed and discards all younger log entries. It returns their new registers and checkpoint slots for use from the next cycle.
- R8: An exception with tag T undoes the entries younger than T, youngest first, one per cycle. `ren_ready` stays low in the request cycle and for one cycle more than the number of undone entries. Afterwards the table matches the state just after T was renamed.
- R9: `ren_ready` is low when the log holds LOG_DEPTH entries.
- R10: `ren_tag` gives the log slot the current instruction takes. Slots are used in order, modulo LOG_DEPTH, and a recovery rewinds the next slot to just after the branch or the faulting entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ren_valid | input | 1 | A decoded instruction is presented |
| ren_is_branch | input | 1 | The instruction is a branch that needs a checkpoint |
| ren_src_a | input | AW | First source architectural register |
| ren_src_b | input | AW | Second source architectural register |
| ren_dst | input | AW | Destination architectural register (0 = none) |
| ren_ready | output | 1 | The rename is accepted this cycle |
| ren_psrc_a | output | PW | Physical tag of the first source |
| ren_psrc_b | output | PW | Physical tag of the second source |
| ren_pdst | output | PW | Newly allocated physical destination |
| ren_pold | output | PW | Physical register the destination mapped to before |
| ren_tag | output | LW | Log slot taken by this instruction |
| ren_ckpt | output | CW | Checkpoint slot taken by a branch |
| cmt_valid | input | 1 | Retire the oldest log entry |
| br_recover | input | 1 | Mispredicted branch; restore from a checkpoint |
| br_ckpt | input | CW | Checkpoint slot of the mispredicted branch |
| exc_valid | input | 1 | Exception; undo entries younger than `exc_tag` |
| exc_tag | input | LW | Log slot of the faulting instruction |

## Verification
The embedded assertions check the following on every cycle:
- the pinned zero mapping;
- that allocation happens only when a register or checkpoint slot is idle;
- that only busy registers and slots are released;
- the log occupancy bound;
- the one-entry retreat of each walk step;
- that a source read of the register being written never returns the fresh tag.

The correctness of the values needs the bench's scenarios, driven against a behavioural model. This covers which tag is reported, the restored mappings after checkpoint restore and after a walk, the exact length of the stall during a walk, and the reuse of freed registers one cycle later.

// File: rtl/rn_pkg.sv
// Shared types for the rename unit.
// Assumes: nothing beyond the standard language.
package rn_pkg;
    // Control mode of the rename log: normal operation or exception walk-back.
    typedef enum logic {
        RN_RUN  = 1'b0,
        RN_WALK = 1'b1
    } rn_mode_e;
endpackage

// File: rtl/rn_free_pool.sv
// Physical register free pool held as one bit per register.
// Grants the lowest-numbered free register; takes any number of releases per cycle.
// Assumes: a release names only busy registers; alloc_en only when avail is high.
module rn_free_pool #(
    parameter int PHYS_REGS = 16,
    parameter int ARCH_REGS = 8,
    localparam int PW = $clog2(PHYS_REGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_en,
    input  logic [PHYS_REGS-1:0] release_mask,
    output logic [PW-1:0]        grant,
    output logic                 avail
);
    logic [PHYS_REGS-1:0] free_q;
    logic [PHYS_REGS-1:0] take;

    // Lowest free index wins: a descending scan leaves the smallest hit.
    always_comb begin
        grant = '0;
        for (int i = PHYS_REGS - 1; i >= 0; i--) begin
            if (free_q[i]) grant = PW'(i);
        end
    end

    assign avail = |free_q;
    assign take  = alloc_en ? (PHYS_REGS'(1) << grant) : '0;

    // Pool state: registers above the architectural range start free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS_REGS; i++) free_q[i] <= (i >= ARCH_REGS);
        end else begin
            free_q <= (free_q & ~take) | release_mask;
        end
    end

    p_alloc_avail_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> avail);
    p_release_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (release_mask & free_q) == '0);
endmodule

// File: rtl/rn_ckpt_store.sv
// Checkpoint slots for branches: each holds a full map table copy and the log
// position just after its branch. Hands out the lowest idle slot.
// Assumes: take_en only when avail; releases name only busy slots.
module rn_ckpt_store #(
    parameter int SLOTS     = 2,
    parameter int ARCH_REGS = 8,
    parameter int PW        = 4,
    parameter int LW        = 4,
    localparam int CW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          take_en,
    input  logic [ARCH_REGS-1:0][PW-1:0]  take_tab,
    input  logic [LW-1:0]                 take_tail,
    input  logic [SLOTS-1:0]              release_mask,
    input  logic [CW-1:0]                 rd_id,
    output logic                          avail,
    output logic [CW-1:0]                 slot,
    output logic [ARCH_REGS-1:0][PW-1:0]  rd_tab,
    output logic [LW-1:0]                 rd_tail
);
    logic [SLOTS-1:0]                 busy_q;
    logic [ARCH_REGS-1:0][PW-1:0]     tab_q  [SLOTS];
    logic [LW-1:0]                    tail_q [SLOTS];
    logic [SLOTS-1:0]                 take_mask;

    // Lowest idle slot selection.
    always_comb begin
        slot = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!busy_q[i]) slot = CW'(i);
        end
    end

    assign avail     = ~&busy_q;
    assign take_mask = take_en ? (SLOTS'(1) << slot) : '0;
    assign rd_tab    = tab_q[rd_id];
    assign rd_tail   = tail_q[rd_id];

    // Occupancy of the slots.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= (busy_q & ~release_mask) | take_mask;
    end

    // Snapshot payload; contents matter only while the slot is busy.
    always_ff @(posedge clk) begin
        if (take_en) begin
            tab_q[slot]  <= take_tab;
            tail_q[slot] <= take_tail;
        end
    end

    p_take_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_en |-> avail);
    p_release_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (release_mask & ~busy_q) == '0);
endmodule

// File: rtl/rn_map_table.sv
// Architectural-to-physical map table with three read ports, one write port
// and a whole-table load used for checkpoint restore.
// Assumes: load_en and wr_en are never set together; with ZERO_EN the caller
// never writes entry 0.
module rn_map_table #(
    parameter int ARCH_REGS = 8,
    parameter int PW        = 4,
    parameter bit ZERO_EN   = 1'b1,
    localparam int AW = $clog2(ARCH_REGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_arch,
    input  logic [PW-1:0]                 wr_phys,
    input  logic                          load_en,
    input  logic [ARCH_REGS-1:0][PW-1:0]  load_tab,
    input  logic [AW-1:0]                 rd_a,
    input  logic [AW-1:0]                 rd_b,
    input  logic [AW-1:0]                 rd_c,
    output logic [PW-1:0]                 q_a,
    output logic [PW-1:0]                 q_b,
    output logic [PW-1:0]                 q_c,
    output logic [ARCH_REGS-1:0][PW-1:0]  upd_tab
);
    logic [ARCH_REGS-1:0][PW-1:0] map_q;

    // Reads see the table before this cycle's write.
    assign q_a = map_q[rd_a];
    assign q_b = map_q[rd_b];
    assign q_c = map_q[rd_c];

    // Table with this cycle's single write applied (next state and snapshot).
    always_comb begin
        upd_tab = map_q;
        if (wr_en) upd_tab[wr_arch] = wr_phys;
    end

    // Table state: identity at reset, restore or single update afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= PW'(i);
        end else if (load_en) begin
            map_q <= load_tab;
        end else begin
            map_q <= upd_tab;
        end
    end

    if (ZERO_EN) begin : g_zero
        p_zero_pinned_r4: assert property (@(posedge clk) disable iff (!rst_n)
            map_q[0] == '0);
        p_zero_unwritten_r4: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |-> (wr_arch != '0));
    end
endmodule

// File: rtl/rn_rename_unit.sv
// Single-issue register rename unit. Translates sources through the map table,
// allocates a fresh destination, logs the displaced mapping in an in-order
// rename log, checkpoints the table at branches, restores a checkpoint on a
// mispredict and walks the log backwards on an exception.
// Assumes: LOG_DEPTH is a power of two; br_recover and exc_valid are not raised
// together nor during a walk; br_ckpt names a busy slot whose branch is in the
// log; exc_tag names an entry in the log.
module rn_rename_unit #(
    parameter int ARCH_REGS  = 8,
    parameter int PHYS_REGS  = 16,
    parameter int LOG_DEPTH  = 16,
    parameter int CKPT_SLOTS = 2,
    parameter bit ZERO_EN    = 1'b1,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int PW = $clog2(PHYS_REGS),
    localparam int LW = $clog2(LOG_DEPTH),
    localparam int CW = (CKPT_SLOTS > 1) ? $clog2(CKPT_SLOTS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren_valid,
    input  logic          ren_is_branch,
    input  logic [AW-1:0] ren_src_a,
    input  logic [AW-1:0] ren_src_b,
    input  logic [AW-1:0] ren_dst,
    output logic          ren_ready,
    output logic [PW-1:0] ren_psrc_a,
    output logic [PW-1:0] ren_psrc_b,
    output logic [PW-1:0] ren_pdst,
    output logic [PW-1:0] ren_pold,
    output logic [LW-1:0] ren_tag,
    output logic [CW-1:0] ren_ckpt,
    input  logic          cmt_valid,
    input  logic          br_recover,
    input  logic [CW-1:0] br_ckpt,
    input  logic          exc_valid,
    input  logic [LW-1:0] exc_tag
);
    import rn_pkg::*;

    localparam logic [LW:0] DEPTH_N = (LW+1)'(LOG_DEPTH);

    // Rename log storage and pointers.
    logic [LOG_DEPTH-1:0] lg_has_q, lg_br_q;
    logic [AW-1:0]        lg_arch_q [LOG_DEPTH];
    logic [PW-1:0]        lg_new_q  [LOG_DEPTH];
    logic [PW-1:0]        lg_old_q  [LOG_DEPTH];
    logic [CW-1:0]        lg_ck_q   [LOG_DEPTH];
    logic [LW-1:0]        head_q, tail_q, walk_stop_q;
    logic [LW:0]          cnt_q;
    rn_mode_e             mode_q;

    // Interconnect.
    logic                          needs_alloc, fire, do_alloc, do_commit, walk_step;
    logic                          log_full, recov_req;
    logic [LW-1:0]                 widx;
    logic                          fp_avail, ck_avail;
    logic [PW-1:0]                 fp_grant, cur_dst_map;
    logic [PHYS_REGS-1:0]          fp_rel;
    logic [CKPT_SLOTS-1:0]         ck_rel;
    logic [CW-1:0]                 ck_slot;
    logic [ARCH_REGS-1:0][PW-1:0]  upd_tab, ck_rd_tab;
    logic [LW-1:0]                 ck_rd_tail, keep_raw;
    logic [LW:0]                   keep_n, sq_n;
    logic [LOG_DEPTH-1:0]          sq_mask;
    logic                          map_wr_en;
    logic [AW-1:0]                 map_wr_arch;
    logic [PW-1:0]                 map_wr_phys;

    // Acceptance and step qualifiers.
    always_comb begin
        needs_alloc = ZERO_EN ? (ren_dst != '0) : 1'b1;
        recov_req   = br_recover | exc_valid;
        log_full    = (cnt_q == DEPTH_N);
        ren_ready   = (mode_q == RN_RUN) && !recov_req && !log_full &&
                      (!needs_alloc || fp_avail) && (!ren_is_branch || ck_avail);
        fire        = ren_valid && ren_ready;
        do_alloc    = fire && needs_alloc;
        do_commit   = cmt_valid && (cnt_q != '0) && (mode_q == RN_RUN) && !recov_req;
        walk_step   = (mode_q == RN_WALK) && (tail_q != walk_stop_q);
        widx        = tail_q - 1'b1;
    end

    // Entries younger than the recovered branch: those between the restored
    // tail and the current tail. A branch still in the log keeps at least one.
    always_comb begin
        logic [LW-1:0] off;
        keep_raw = ck_rd_tail - head_q;
        keep_n   = (keep_raw == '0) ? DEPTH_N : {1'b0, keep_raw};
        sq_n     = cnt_q - keep_n;
        for (int i = 0; i < LOG_DEPTH; i++) begin
            off        = LW'(i) - ck_rd_tail;
            sq_mask[i] = br_recover && ({1'b0, off} < sq_n);
        end
    end

    // Registers and checkpoint slots handed back this cycle.
    always_comb begin
        fp_rel = '0;
        ck_rel = '0;
        if (do_commit) begin
            if (lg_has_q[head_q]) fp_rel[lg_old_q[head_q]] = 1'b1;
            if (lg_br_q[head_q])  ck_rel[lg_ck_q[head_q]]  = 1'b1;
        end
        if (walk_step) begin
            if (lg_has_q[widx]) fp_rel[lg_new_q[widx]] = 1'b1;
            if (lg_br_q[widx])  ck_rel[lg_ck_q[widx]]  = 1'b1;
        end
        if (br_recover) begin
            ck_rel[br_ckpt] = 1'b1;
            for (int i = 0; i < LOG_DEPTH; i++) begin
                if (sq_mask[i] && lg_has_q[i]) fp_rel[lg_new_q[i]] = 1'b1;
                if (sq_mask[i] && lg_br_q[i])  ck_rel[lg_ck_q[i]]  = 1'b1;
            end
        end
    end

    // Map write: a rename update or one undo step of the walk.
    always_comb begin
        map_wr_en   = do_alloc || (walk_step && lg_has_q[widx]);
        map_wr_arch = walk_step ? lg_arch_q[widx] : ren_dst;
        map_wr_phys = walk_step ? lg_old_q[widx]  : fp_grant;
    end

    rn_map_table #(.ARCH_REGS(ARCH_REGS), .PW(PW), .ZERO_EN(ZERO_EN)) u_map (
        .clk(clk), .rst_n(rst_n),
        .wr_en(map_wr_en), .wr_arch(map_wr_arch), .wr_phys(map_wr_phys),
        .load_en(br_recover), .load_tab(ck_rd_tab),
        .rd_a(ren_src_a), .rd_b(ren_src_b), .rd_c(ren_dst),
        .q_a(ren_psrc_a), .q_b(ren_psrc_b), .q_c(cur_dst_map),
        .upd_tab(upd_tab)
    );

    rn_free_pool #(.PHYS_REGS(PHYS_REGS), .ARCH_REGS(ARCH_REGS)) u_pool (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(do_alloc), .release_mask(fp_rel),
        .grant(fp_grant), .avail(fp_avail)
    );

    rn_ckpt_store #(.SLOTS(CKPT_SLOTS), .ARCH_REGS(ARCH_REGS), .PW(PW), .LW(LW)) u_ckpt (
        .clk(clk), .rst_n(rst_n),
        .take_en(fire && ren_is_branch), .take_tab(upd_tab),
        .take_tail(tail_q + 1'b1), .release_mask(ck_rel),
        .rd_id(br_ckpt), .avail(ck_avail), .slot(ck_slot),
        .rd_tab(ck_rd_tab), .rd_tail(ck_rd_tail)
    );

    assign ren_pdst = needs_alloc ? fp_grant : '0;
    assign ren_pold = needs_alloc ? cur_dst_map : '0;
    assign ren_tag  = tail_q;
    assign ren_ckpt = ck_slot;

    // Log pointers, occupancy, walk control and per-entry flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q      <= '0;
            tail_q      <= '0;
            cnt_q       <= '0;
            walk_stop_q <= '0;
            mode_q      <= RN_RUN;
            lg_has_q    <= '0;
            lg_br_q     <= '0;
        end else if (br_recover) begin
            tail_q                    <= ck_rd_tail;
            cnt_q                     <= keep_n;
            lg_br_q[ck_rd_tail - 1'b1] <= 1'b0;
        end else if (exc_valid) begin
            mode_q      <= RN_WALK;
            walk_stop_q <= exc_tag + 1'b1;
        end else if (mode_q == RN_WALK) begin
            if (walk_step) begin
                tail_q <= widx;
                cnt_q  <= cnt_q - 1'b1;
            end else begin
                mode_q <= RN_RUN;
            end
        end else begin
            if (fire) begin
                lg_has_q[tail_q] <= needs_alloc;
                lg_br_q[tail_q]  <= ren_is_branch;
                tail_q           <= tail_q + 1'b1;
            end
            if (do_commit) head_q <= head_q + 1'b1;
            cnt_q <= cnt_q + (LW+1)'(fire) - (LW+1)'(do_commit);
        end
    end

    // Log payload written at the tail on each accepted rename.
    always_ff @(posedge clk) begin
        if (fire && (mode_q == RN_RUN)) begin
            lg_arch_q[tail_q] <= ren_dst;
            lg_new_q[tail_q]  <= fp_grant;
            lg_old_q[tail_q]  <= cur_dst_map;
            lg_ck_q[tail_q]   <= ck_slot;
        end
    end

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= DEPTH_N);
    p_walk_retreat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        walk_step |=> (tail_q == $past(tail_q) - 1'b1));
    p_commit_shrink_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (do_commit && !fire) |=> (cnt_q == $past(cnt_q) - 1'b1));
    p_fire_grow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !do_commit) |=> (tail_q == $past(tail_q) + 1'b1));
    p_recover_trim_r7: assert property (@(posedge clk) disable iff (!rst_n)
        br_recover |=> (cnt_q <= $past(cnt_q)));
    p_src_not_fresh_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (do_alloc && (ren_src_a == ren_dst)) |-> (ren_psrc_a != ren_pdst));
endmodule

// File: tb/test_rn_rename_unit.sv
// Bench: behavioural model (queue log, integer tables) compared every cycle.
module test_rn_rename_unit;
    localparam int A = 8;
    localparam int P = 16;
    localparam int D = 16;
    localparam int C = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n;
    logic       ren_valid, ren_is_branch;
    logic [2:0] ren_src_a, ren_src_b, ren_dst;
    logic       ren_ready;
    logic [3:0] ren_psrc_a, ren_psrc_b, ren_pdst, ren_pold, ren_tag;
    logic [0:0] ren_ckpt;
    logic       cmt_valid, br_recover, exc_valid;
    logic [0:0] br_ckpt;
    logic [3:0] exc_tag;

    rn_rename_unit #(.ARCH_REGS(A), .PHYS_REGS(P), .LOG_DEPTH(D), .CKPT_SLOTS(C)) i_rn_rename_unit (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_is_branch(ren_is_branch),
        .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_dst(ren_dst),
        .ren_ready(ren_ready), .ren_psrc_a(ren_psrc_a), .ren_psrc_b(ren_psrc_b),
        .ren_pdst(ren_pdst), .ren_pold(ren_pold), .ren_tag(ren_tag), .ren_ckpt(ren_ckpt),
        .cmt_valid(cmt_valid), .br_recover(br_recover), .br_ckpt(br_ckpt),
        .exc_valid(exc_valid), .exc_tag(exc_tag)
    );

    typedef struct {
        bit has; int arch; int newp; int oldp; bit isbr; int ck; int idx;
    } ent_t;

    ent_t mlog[$];
    int   mmap[A];
    bit   mfree[P];
    bit   ckb[C];
    int   ckmap[C][A];
    int   mtail, walk_rem;
    int   checks = 0, failures = 0;
    bit   done = 1'b0;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int low_free();
        for (int i = 0; i < P; i++) if (mfree[i]) return i;
        return -1;
    endfunction

    function automatic int low_ck();
        for (int i = 0; i < C; i++) if (!ckb[i]) return i;
        return -1;
    endfunction

    function automatic bit exp_ready();
        if (walk_rem > 0 || br_recover || exc_valid) return 1'b0;
        if (mlog.size() == D) return 1'b0;
        if (ren_dst != 0 && low_free() < 0) return 1'b0;
        if (ren_is_branch && low_ck() < 0) return 1'b0;
        return 1'b1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < A; i++) mmap[i] = i;
        for (int i = 0; i < P; i++) mfree[i] = (i >= A);
        for (int i = 0; i < C; i++) ckb[i] = 1'b0;
        mlog.delete();
        mtail = 0;
        walk_rem = 0;
    endtask

    task automatic idle();
        ren_valid = 0; ren_is_branch = 0; ren_src_a = 0; ren_src_b = 0; ren_dst = 0;
        cmt_valid = 0; br_recover = 0; br_ckpt = 0; exc_valid = 0; exc_tag = 0;
    endtask

    task automatic do_recover(int id);
        int p = -1;
        ent_t e;
        for (int i = 0; i < mlog.size(); i++) if (mlog[i].isbr && mlog[i].ck == id) p = i;
        while (mlog.size() > p + 1) begin
            e = mlog.pop_back();
            if (e.has) mfree[e.newp] = 1'b1;
            if (e.isbr) ckb[e.ck] = 1'b0;
        end
        e = mlog[p];
        e.isbr = 1'b0;
        mlog[p] = e;
        ckb[id] = 1'b0;
        for (int i = 0; i < A; i++) mmap[i] = ckmap[id][i];
        mtail = (e.idx + 1) % D;
    endtask

    task automatic do_exc(int t);
        int p = -1;
        int n = 0;
        ent_t e;
        for (int i = 0; i < mlog.size(); i++) if (mlog[i].idx == t) p = i;
        while (mlog.size() > p + 1) begin
            e = mlog.pop_back();
            if (e.has) begin mmap[e.arch] = e.oldp; mfree[e.newp] = 1'b1; end
            if (e.isbr) ckb[e.ck] = 1'b0;
            n++;
        end
        mtail = (t + 1) % D;
        walk_rem = n + 1;
    endtask

    // One cycle: compare outputs mid-cycle, then advance the model at the edge.
    task automatic step(string tag);
        bit er, need, com;
        ent_t e, c;
        #1;
        er   = exp_ready();
        need = (ren_dst != 0);
        chk(tag, "ready", int'(ren_ready), int'(er));
        if (ren_valid && er) begin
            chk(tag, "psrc_a", int'(ren_psrc_a), mmap[ren_src_a]);
            chk(tag, "psrc_b", int'(ren_psrc_b), mmap[ren_src_b]);
            chk(tag, "pdst", int'(ren_pdst), need ? low_free() : 0);
            chk(tag, "pold", int'(ren_pold), mmap[ren_dst]);
            chk(tag, "tag", int'(ren_tag), mtail);
            if (ren_is_branch) chk(tag, "ckpt", int'(ren_ckpt), low_ck());
        end
        @(posedge clk);
        if (br_recover) do_recover(int'(br_ckpt));
        else if (exc_valid) do_exc(int'(exc_tag));
        else if (walk_rem > 0) walk_rem--;
        else begin
            com = cmt_valid && mlog.size() > 0;
            if (ren_valid && er) begin
                e.has = need; e.arch = ren_dst; e.newp = 0; e.oldp = mmap[ren_dst];
                e.isbr = ren_is_branch; e.ck = 0; e.idx = mtail;
                if (need) begin
                    e.newp = low_free();
                    mfree[e.newp] = 1'b0;
                    mmap[ren_dst] = e.newp;
                end
                if (ren_is_branch) begin
                    e.ck = low_ck();
                    ckb[e.ck] = 1'b1;
                    for (int i = 0; i < A; i++) ckmap[e.ck][i] = mmap[i];
                end
                mtail = (mtail + 1) % D;
                mlog.push_back(e);
            end
            if (com) begin
                c = mlog.pop_front();
                if (c.has) mfree[c.oldp] = 1'b1;
                if (c.isbr) ckb[c.ck] = 1'b0;
            end
        end
        @(negedge clk);
    endtask

    task automatic rename(bit br, int sa, int sb, int d);
        idle();
        ren_valid = 1; ren_is_branch = br;
        ren_src_a = 3'(sa); ren_src_b = 3'(sb); ren_dst = 3'(d);
    endtask

    task automatic drain();
        while (mlog.size() > 0 || walk_rem > 0) begin
            idle(); cmt_valid = 1; step("R5");
        end
        idle();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int t, p4, n, r, pick;
        bit busy_found;
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_reset();

        // R1: identity map and free pool after reset
        ren_src_a = 5; ren_src_b = 7;
        #1;
        chk("R1", "ready", int'(ren_ready), 1);
        chk("R1", "psrc_a", int'(ren_psrc_a), 5);
        chk("R1", "psrc_b", int'(ren_psrc_b), 7);
        step("R1");

        // R2: source read before own destination update
        rename(0, 1, 2, 1);
        #1;
        chk("R2", "psrc_a", int'(ren_psrc_a), 1);
        chk("R2", "pdst", int'(ren_pdst), 8);
        chk("R2", "pold", int'(ren_pold), 1);
        step("R2");

        // R4: register zero stays pinned
        rename(0, 0, 0, 0);
        #1;
        chk("R4", "psrc_a", int'(ren_psrc_a), 0);
        chk("R4", "pdst", int'(ren_pdst), 0);
        chk("R4", "pold", int'(ren_pold), 0);
        step("R4");

        // R5: commit frees old mapping (1), reused next cycle
        idle(); cmt_valid = 1; step("R5");
        rename(0, 1, 0, 3);
        #1;
        chk("R5", "pdst_reuse", int'(ren_pdst), 1);
        chk("R5", "psrc_a", int'(ren_psrc_a), 8);
        step("R5");
        drain();
        idle(); cmt_valid = 1; step("R5");

        // R6 / R7: checkpoints and branch recovery
        rename(1, 0, 0, 0);
        #1; chk("R6", "ckpt", int'(ren_ckpt), 0);
        step("R6");
        rename(0, 2, 0, 2); step("R7");
        rename(1, 0, 0, 0);
        #1; chk("R6", "ckpt", int'(ren_ckpt), 1);
        step("R6");
        rename(1, 0, 0, 0);
        #1; chk("R6", "ready_no_slot", int'(ren_ready), 0);
        step("R6");
        idle(); br_recover = 1; br_ckpt = 0;
        #1; chk("R7", "ready_in_recover", int'(ren_ready), 0);
        step("R7");
        rename(1, 2, 0, 0);
        #1;
        chk("R7", "psrc_restored", int'(ren_psrc_a), 2);
        chk("R7", "ckpt_reused", int'(ren_ckpt), 0);
        step("R7");
        drain();

        // R8: exception walk-back
        rename(0, 0, 0, 4);
        t = mtail;
        #1; p4 = int'(ren_pdst);
        step("R8");
        rename(0, 4, 0, 4); step("R8");
        rename(0, 4, 1, 4); step("R8");
        idle(); exc_valid = 1; exc_tag = 4'(t);
        #1; chk("R8", "ready_in_exc", int'(ren_ready), 0);
        step("R8");
        n = 0;
        for (int k = 0; k < 10; k++) begin
            idle(); ren_valid = 1; ren_src_a = 4;
            #1;
            if (ren_ready) break;
            step("R8");
            n++;
        end
        chk("R8", "walk_cycles", n, 3);
        chk("R8", "psrc_restored", int'(ren_psrc_a), p4);
        step("R8");
        drain();

        // R3: free pool exhaustion
        for (int k = 0; k < 8; k++) begin
            rename(0, k % 8, 0, (k % 7) + 1); step("R3");
        end
        rename(0, 0, 0, 5);
        #1; chk("R3", "ready_no_reg", int'(ren_ready), 0);
        step("R3");
        drain();

        // R5: commit on empty log ignored
        idle(); cmt_valid = 1; step("R5");

        // R9: log full
        for (int k = 0; k < D; k++) begin
            rename(0, 1, 2, 0); step("R9");
        end
        rename(0, 1, 2, 0);
        #1; chk("R9", "ready_full", int'(ren_ready), 0);
        step("R9");
        drain();

        // R10: mixed traffic against the model
        for (int k = 0; k < 3000; k++) begin
            idle();
            r = $urandom_range(0, 99);
            busy_found = 0;
            pick = 0;
            for (int i = 0; i < C; i++) if (ckb[i] && !busy_found) begin busy_found = 1; pick = i; end
            if (walk_rem == 0 && r < 4 && busy_found) begin
                if (ckb[1] && $urandom_range(0, 1) == 1) pick = 1;
                br_recover = 1; br_ckpt = 1'(pick);
                step("R7");
            end else if (walk_rem == 0 && r < 7 && mlog.size() > 0) begin
                exc_valid = 1;
                exc_tag = 4'(mlog[$urandom_range(0, mlog.size() - 1)].idx);
                step("R8");
            end else begin
                ren_valid     = ($urandom_range(0, 99) < 70);
                ren_is_branch = ($urandom_range(0, 99) < 15);
                ren_src_a     = 3'($urandom_range(0, 7));
                ren_src_b     = 3'($urandom_range(0, 7));
                ren_dst       = 3'($urandom_range(0, 7));
                cmt_valid     = ($urandom_range(0, 99) < 45);
                step("R10");
            end
        end
        drain();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule